// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with LIN Host Header

This block serialises characters onto an idle-high transmit line. The frame format is chosen per write: 5 to 9 data bits, parity off, even or odd, and one or two stop bits. A one-per-bit baud tick from outside sets the bit rate.

A 2-bit header command sent with each write picks how the word goes out. It can go out as a plain character. It can go out after a break field. Or it can be taken as a LIN identifier and follow an automatic break and sync field. A one-entry holding register lets software queue the next word while the current one is shifting out.

The transmit-enable input gates only new writes. Anything already accepted is always sent to the end.

Top module: `lin_usart_tx`

## Requirements
- R1: After reset `txd` is high, `busy` is low and `tx_done` is low.
- R2: A character is one low start bit, then the data bits least-significant first, then the optional parity bit, then the stop bits; the line rests high between frames. Each bit lasts from one `baud_tick` to the next, and the first bit starts at the first tick after the write is accepted.
- R3: `cfg_size_code` selects the data width: 0 gives 8 bits, 1 gives 9, 5 gives 5, 6 gives 6 and 7 gives 7. Codes 2, 3 and 4 give 8 bits. Data bits above the width are not sent.
- R4: With `cfg_par_en` high, a parity bit follows the data bits. With `cfg_par_odd` at 0, the data bits plus parity hold an even number of ones; with it at 1, an odd number.
- R5: `cfg_two_stop` at 0 sends one high stop bit; at 1 it sends two.
- R6: Header command 0 sends the written word as a plain character. Command 3 behaves the same as 0.
- R7: Header command 1 sends 13 low bit times, then one high delimiter bit, then the written word as a character.
- R8: Header command 2 sends the break and delimiter, then the byte 0x55 as 8 data bits with no parity and one stop bit, then the written word as a character in the configured format.
- R9: A write is accepted when `tx_en` is high and the holding register is empty. The held word is sent right after the last stop bit of the previous frame, with no idle bit between them. A write while a word is already held is dropped.
- R10: Writes while `tx_en` is low are ignored. Dropping `tx_en` during a transfer still lets the frame in progress and the held word finish.
- R11: `busy` is high from the cycle after a write is accepted until the tick that ends the final stop bit. `tx_done` pulses for one cycle at that tick. A sync field produces no pulse.
- R12: The frame format and header command are captured at write time. Changing the configuration inputs afterwards does not alter that word's frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Allows new writes to be accepted |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_valid | input | 1 | Data-write strobe |
| wr_data | input | 9 | Word to send (LSB first) |
| cfg_size_code | input | 3 | Data width code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 0 even, 1 odd parity |
| cfg_two_stop | input | 1 | 0 one stop bit, 1 two stop bits |
| cfg_hdr_cmd | input | 2 | Header command for this write |
| txd | output | 1 | Serial transmit line, idle high |
| busy | output | 1 | Word in flight or held |
| tx_done | output | 1 | One-cycle pulse at the end of each written word's frame |

## Verification
The bench sweeps every width code, including the reserved ones, across all parity and stop settings. It catches a width decoder that maps codes 2 to 4 wrongly, and a parity generator that counts bits beyond the chosen width or inverts the even/odd sense.

Header frames are checked bit by bit. A break counter that is one bit short or long, or a sync byte sent with the identifier's format, shows up as a shifted waveform.

Back-to-back writes check two faults. A buffer that overwrites a held word would send the third write. A design that idles between frames would show an extra high bit.

Clearing `tx_en` while a held word is waiting must not lose it. Changing the configuration after a write must not reshape a frame already queued.

// File: rtl/lin_usart_pkg.sv
package lin_usart_pkg;

  localparam int unsigned CHAR_W = 9;
  localparam int unsigned CNT_W  = $clog2(CHAR_W + 1);

  typedef enum logic [1:0] {
    HDR_NONE  = 2'd0,
    HDR_BREAK = 2'd1,
    HDR_AUTO  = 2'd2,
    HDR_RSVD  = 2'd3
  } hdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK,
    ST_DLM,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic [CNT_W-1:0]  nbits;
    logic              par_en;
    logic              par_odd;
    logic              two_stop;
    hdr_cmd_e          cmd;
  } tx_req_t;

  function automatic logic [CNT_W-1:0] width_of_code(input logic [2:0] code);
    case (code)
      3'd1:    width_of_code = CNT_W'(9);
      3'd5:    width_of_code = CNT_W'(5);
      3'd6:    width_of_code = CNT_W'(6);
      3'd7:    width_of_code = CNT_W'(7);
      default: width_of_code = CNT_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/lin_tx_parity.sv
module lin_tx_parity
  import lin_usart_pkg::*;
(
  input  logic [CHAR_W-1:0] data,
  input  logic [CNT_W-1:0]  nbits,
  input  logic              odd,
  output logic              par
);

  logic [CHAR_W-1:0] masked;

  for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
    assign masked[i] = data[i] & (nbits > CNT_W'(i));
  end

  assign par = (^masked) ^ odd;

endmodule

// File: rtl/lin_tx_holdbuf.sv
module lin_tx_holdbuf
  import lin_usart_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    push,
  input  tx_req_t push_req,
  input  logic    pop,
  output logic    full,
  output tx_req_t head
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      head <= '0;
    end else if (pop) begin
      full <= 1'b0;
    end else if (push && !full) begin
      full <= 1'b1;
      head <= push_req;
    end
  end

  AST_HELD_ENTRY_STABLE: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> (full && $stable(head))); // R9

endmodule

// File: rtl/lin_tx_engine.sv
module lin_tx_engine
  import lin_usart_pkg::*;
#(
  parameter int unsigned BREAK_BITS = 13,
  parameter logic [7:0]  SYNC_BYTE  = 8'h55
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    tick,
  input  logic    req_valid,
  input  tx_req_t req,
  output logic    pop,
  output logic    txd,
  output logic    active,
  output logic    done
);

  localparam int unsigned BRK_CW = $clog2(BREAK_BITS + 1);
  localparam logic [BRK_CW-1:0] BRK_LAST = BRK_CW'(BREAK_BITS);

  tx_state_e         st, st_n;
  logic              txd_q, txd_n;
  logic [CHAR_W-1:0] shreg, shreg_n;
  logic [CNT_W-1:0]  bitcnt, bitcnt_n;
  logic [BRK_CW-1:0] brk_cnt, brk_cnt_n;
  logic              stop_more, stop_more_n;
  logic [CNT_W-1:0]  cur_nbits, cur_nbits_n;
  logic              cur_par_en, cur_par_en_n;
  logic              cur_par, cur_par_n;
  logic              cur_two, cur_two_n;
  logic              cur_is_sync, cur_is_sync_n;
  tx_req_t           pend, pend_n;
  logic              sync_pend, sync_pend_n;
  logic              done_q, done_n;

  // Source of the next character to load
  logic              from_pend, ld_is_sync;
  tx_req_t           ld, sync_req;
  logic              ld_par;
  logic              launch, load_char;

  always_comb begin
    sync_req          = '0;
    sync_req.data     = {{(CHAR_W-8){1'b0}}, SYNC_BYTE};
    sync_req.nbits    = CNT_W'(8);
    sync_req.cmd      = HDR_NONE;
    from_pend  = (st == ST_DLM) || (st == ST_STOP && cur_is_sync);
    ld_is_sync = (st == ST_DLM) && sync_pend;
    if (from_pend) ld = ld_is_sync ? sync_req : pend;
    else           ld = req;
  end

  lin_tx_parity u_par (
    .data  (ld.data),
    .nbits (ld.nbits),
    .odd   (ld.par_odd),
    .par   (ld_par)
  );

  always_comb begin
    st_n          = st;
    txd_n         = txd_q;
    shreg_n       = shreg;
    bitcnt_n      = bitcnt;
    brk_cnt_n     = brk_cnt;
    stop_more_n   = stop_more;
    cur_nbits_n   = cur_nbits;
    cur_par_en_n  = cur_par_en;
    cur_par_n     = cur_par;
    cur_two_n     = cur_two;
    cur_is_sync_n = cur_is_sync;
    pend_n        = pend;
    sync_pend_n   = sync_pend;
    done_n        = 1'b0;
    pop           = 1'b0;
    launch        = 1'b0;
    load_char     = 1'b0;

    if (tick) begin
      case (st)
        ST_IDLE: launch = req_valid;
        ST_BRK: begin
          if (brk_cnt == BRK_LAST) begin
            txd_n = 1'b1;
            st_n  = ST_DLM;
          end else begin
            brk_cnt_n = brk_cnt + 1'b1;
          end
        end
        ST_DLM: load_char = 1'b1;
        ST_START: begin
          txd_n    = shreg[0];
          shreg_n  = shreg >> 1;
          bitcnt_n = CNT_W'(1);
          st_n     = ST_DATA;
        end
        ST_DATA: begin
          if (bitcnt == cur_nbits) begin
            stop_more_n = cur_two;
            if (cur_par_en) begin
              txd_n = cur_par;
              st_n  = ST_PAR;
            end else begin
              txd_n = 1'b1;
              st_n  = ST_STOP;
            end
          end else begin
            txd_n    = shreg[0];
            shreg_n  = shreg >> 1;
            bitcnt_n = bitcnt + 1'b1;
          end
        end
        ST_PAR: begin
          txd_n       = 1'b1;
          st_n        = ST_STOP;
          stop_more_n = cur_two;
        end
        ST_STOP: begin
          if (stop_more) begin
            stop_more_n = 1'b0;
          end else if (cur_is_sync) begin
            load_char = 1'b1;
          end else begin
            done_n = 1'b1;
            txd_n  = 1'b1;
            st_n   = ST_IDLE;
            launch = req_valid;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end

    if (launch) begin
      pop = 1'b1;
      if (req.cmd == HDR_BREAK || req.cmd == HDR_AUTO) begin
        st_n        = ST_BRK;
        txd_n       = 1'b0;
        brk_cnt_n   = BRK_CW'(1);
        pend_n      = req;
        sync_pend_n = (req.cmd == HDR_AUTO);
      end else begin
        load_char = 1'b1;
      end
    end

    if (load_char) begin
      st_n          = ST_START;
      txd_n         = 1'b0;
      shreg_n       = ld.data;
      cur_nbits_n   = ld.nbits;
      cur_par_en_n  = ld.par_en;
      cur_par_n     = ld_par;
      cur_two_n     = ld.two_stop;
      cur_is_sync_n = ld_is_sync;
      if (ld_is_sync) sync_pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      txd_q       <= 1'b1;
      shreg       <= '0;
      bitcnt      <= '0;
      brk_cnt     <= '0;
      stop_more   <= 1'b0;
      cur_nbits   <= '0;
      cur_par_en  <= 1'b0;
      cur_par     <= 1'b0;
      cur_two     <= 1'b0;
      cur_is_sync <= 1'b0;
      pend        <= '0;
      sync_pend   <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      st          <= st_n;
      txd_q       <= txd_n;
      shreg       <= shreg_n;
      bitcnt      <= bitcnt_n;
      brk_cnt     <= brk_cnt_n;
      stop_more   <= stop_more_n;
      cur_nbits   <= cur_nbits_n;
      cur_par_en  <= cur_par_en_n;
      cur_par     <= cur_par_n;
      cur_two     <= cur_two_n;
      cur_is_sync <= cur_is_sync_n;
      pend        <= pend_n;
      sync_pend   <= sync_pend_n;
      done_q      <= done_n;
    end
  end

  assign txd    = txd_q;
  assign active = (st != ST_IDLE);
  assign done   = done_q;

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> txd_q); // R2
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START) |-> !txd_q); // R2
  AST_DATA_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA) |-> (bitcnt >= CNT_W'(1) && bitcnt <= cur_nbits)); // R3
  AST_STOP_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOP) |-> txd_q); // R5
  AST_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BRK) |-> !txd_q); // R7
  AST_BREAK_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BRK) |-> (brk_cnt >= BRK_CW'(1) && brk_cnt <= BRK_LAST)); // R7
  AST_DELIM_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DLM) |-> txd_q); // R7
  AST_POP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    pop |-> (tick && req_valid)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R11

endmodule

// File: rtl/lin_usart_tx.sv
module lin_usart_tx
  import lin_usart_pkg::*;
#(
  parameter int unsigned BREAK_BITS = 13,
  parameter logic [7:0]  SYNC_BYTE  = 8'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              wr_valid,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic [2:0]        cfg_size_code,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic [1:0]        cfg_hdr_cmd,
  output logic              txd,
  output logic              busy,
  output logic              tx_done
);

  tx_req_t new_req, head;
  logic    hb_full, hb_pop, push, eng_active;

  always_comb begin
    new_req          = '0;
    new_req.data     = wr_data;
    new_req.nbits    = width_of_code(cfg_size_code);
    new_req.par_en   = cfg_par_en;
    new_req.par_odd  = cfg_par_odd;
    new_req.two_stop = cfg_two_stop;
    new_req.cmd      = hdr_cmd_e'(cfg_hdr_cmd);
  end

  assign push = wr_valid && tx_en && !hb_full;

  lin_tx_holdbuf u_hold (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_req (new_req),
    .pop      (hb_pop),
    .full     (hb_full),
    .head     (head)
  );

  lin_tx_engine #(
    .BREAK_BITS (BREAK_BITS),
    .SYNC_BYTE  (SYNC_BYTE)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .tick      (baud_tick),
    .req_valid (hb_full),
    .req       (head),
    .pop       (hb_pop),
    .txd       (txd),
    .active    (eng_active),
    .done      (tx_done)
  );

  assign busy = eng_active | hb_full;

  AST_NO_ACCEPT_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !hb_full) |=> !hb_full); // R10
  AST_IDLE_WHEN_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd); // R11

endmodule

// File: tb/lin_usart_tx_tb.sv
module lin_usart_tx_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b1;
  logic       baud_tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic [2:0] cfg_size_code = '0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic [1:0] cfg_hdr_cmd = '0;
  logic       txd, busy, tx_done;

  int tests = 0;
  int fails = 0;

  logic exp_bits [0:255];
  int   exp_len, pos, mism, dones, bad_idx, bad_act, bad_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_usart_tx u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .baud_tick(baud_tick),
    .wr_valid(wr_valid), .wr_data(wr_data), .cfg_size_code(cfg_size_code),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_hdr_cmd(cfg_hdr_cmd),
    .txd(txd), .busy(busy), .tx_done(tx_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int width_of(input int code);
    case (code)
      1: return 9;
      5: return 5;
      6: return 6;
      7: return 7;
      default: return 8;
    endcase
  endfunction

  task automatic clear_exp();
    exp_len = 0; pos = 0; mism = 0; dones = 0;
    bad_idx = -1; bad_act = 0; bad_exp = 0;
  endtask

  task automatic add_bit(input logic b);
    exp_bits[exp_len] = b;
    exp_len++;
  endtask

  task automatic add_char(input int data, input int nb, input int pe,
                          input int odd, input int two);
    int ones = 0;
    add_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      add_bit(((data >> i) & 1) != 0);
      ones += (data >> i) & 1;
    end
    if (pe != 0) add_bit(((ones & 1) ^ odd) != 0);
    add_bit(1'b1);
    if (two != 0) add_bit(1'b1);
  endtask

  task automatic add_break();
    for (int i = 0; i < 13; i++) add_bit(1'b0);
    add_bit(1'b1);
  endtask

  task automatic wr(input int data, input int code, input int pe, input int odd,
                    input int two, input int cmd);
    @(negedge clk);
    wr_data       = 9'(data);
    cfg_size_code = 3'(code);
    cfg_par_en    = pe[0];
    cfg_par_odd   = odd[0];
    cfg_two_stop  = two[0];
    cfg_hdr_cmd   = 2'(cmd);
    wr_valid      = 1'b1;
    @(negedge clk);
    wr_valid      = 1'b0;
  endtask

  task automatic tick_check();
    @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
    if (pos < exp_len) begin
      if (txd !== exp_bits[pos] || busy !== 1'b1) begin
        if (mism == 0) begin
          bad_idx = pos; bad_act = int'(txd); bad_exp = int'(exp_bits[pos]);
        end
        mism++;
      end
      pos++;
    end
    if (tx_done === 1'b1) dones++;
    @(negedge clk);
  endtask

  task automatic end_frame(input string req, input int exp_done);
    while (pos < exp_len) tick_check();
    tick_check();
    check(mism == 0, req, $sformatf("waveform bit %0d", bad_idx), bad_act, bad_exp);
    check(busy === 1'b0 && txd === 1'b1, req, "idle after frame (busy,txd)",
          int'({busy, txd}), 1);
    check(dones == exp_done, req, "tx_done pulses", dones, exp_done);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(txd === 1'b1 && busy === 1'b0 && tx_done === 1'b0, "R1",
          "reset (txd,busy,done)", int'({txd, busy, tx_done}), 3'b100);

    // R2 plain 8N1 frame; R11 busy from the write
    clear_exp();
    wr(9'h0A5, 0, 0, 0, 0, 0);
    check(busy === 1'b1, "R11", "busy after accept", int'(busy), 1);
    add_char(9'h0A5, 8, 0, 0, 0);
    end_frame("R2", 1);

    // R3 R4 R5 sweep over every size code, parity mode and stop count
    for (int code = 0; code < 8; code++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int st = 0; st < 2; st++) begin
          int d = (code * 6 + pm * 2 + st) * 73 + 29;
          d = d % 512;
          clear_exp();
          wr(d, code, (pm != 0) ? 1 : 0, (pm == 2) ? 1 : 0, st, 0);
          add_char(d, width_of(code), (pm != 0) ? 1 : 0, (pm == 2) ? 1 : 0, st);
          end_frame($sformatf("R3 R4 R5 code=%0d pm=%0d st=%0d", code, pm, st), 1);
        end
      end
    end

    // R6 reserved command 3 acts as plain
    clear_exp();
    wr(9'h13C, 1, 1, 0, 0, 3);
    add_char(9'h13C, 9, 1, 0, 0);
    end_frame("R6", 1);

    // R7 break then character
    clear_exp();
    wr(9'h05A, 7, 1, 1, 1, 1);
    add_break();
    add_char(9'h05A, 7, 1, 1, 1);
    end_frame("R7", 1);

    // R8 automatic break, sync, identifier
    clear_exp();
    wr(9'h0C1, 0, 1, 0, 0, 2);
    add_break();
    add_char(8'h55, 8, 0, 0, 0);
    add_char(9'h0C1, 8, 1, 0, 0);
    end_frame("R8", 1);

    // R9 R12 held word sent back-to-back, third write dropped, cfg captured
    clear_exp();
    wr(9'h033, 5, 0, 0, 0, 0);
    add_char(9'h033, 5, 0, 0, 0);
    add_char(9'h1E7, 6, 1, 1, 1);
    tick_check();
    wr(9'h1E7, 6, 1, 1, 1, 0);
    wr(9'h0FF, 0, 0, 0, 0, 0);
    cfg_size_code = 3'd1; cfg_par_en = 1'b0; cfg_two_stop = 1'b0; cfg_hdr_cmd = 2'd1;
    end_frame("R9 R12", 2);

    // R10 write ignored while disabled
    tx_en = 1'b0;
    clear_exp();
    wr(9'h000, 0, 0, 0, 0, 0);
    check(busy === 1'b0, "R10", "busy after disabled write", int'(busy), 0);
    for (int i = 0; i < 4; i++) tick_check();
    check(txd === 1'b1 && busy === 1'b0, "R10", "line after disabled write",
          int'({busy, txd}), 1);
    check(dones == 0, "R10", "tx_done pulses when disabled", dones, 0);

    // R10 clearing enable mid-frame still finishes current and held words
    tx_en = 1'b1;
    clear_exp();
    wr(9'h0AA, 0, 0, 0, 1, 0);
    add_char(9'h0AA, 8, 0, 0, 1);
    add_char(9'h011, 5, 1, 0, 0);
    tick_check();
    wr(9'h011, 5, 1, 0, 0, 0);
    tx_en = 1'b0;
    end_frame("R10", 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule